// File: doc/BRIEF.md
# Packet-Atomic Virtual Circuit Merge Unit

This block sits on the output side of a cell switch port. Cells arrive one per slot. Each cell carries a source port number, a 5-byte cell header and a 48-byte payload. A context table of `NUM_VC` entries maps each (source port, incoming VCI) pair to a context. Each context owns one logical reassembly queue. The block holds every cell of a packet in that queue until the cell that ends the packet arrives. It then splices the whole packet onto a single output FIFO. Because the move is one pointer update, the packet leaves as one uninterrupted run. Several contexts may share one outgoing VCI, so packets from many incoming circuits merge onto one label and their cells never interleave.

All queues are linked lists in one shared pool of `POOL_CELLS` cell slots, with a free list. If the pool is exhausted, the arriving cell is dropped and its context discards every further cell up to and including the next end-of-packet cell. The cells that context already held go back to the free list, so a partial packet is never sent. Completed packets wait for the single transfer slot. They are served in round-robin order of context index, one transfer per clock.

Both data interfaces are valid/ready. A cell is taken on the input when `in_valid` and `in_ready` are both high. `in_ready` drops only while the addressed context still has a completed packet waiting to be moved, which lasts at most a few cycles. On the output, the presented cell and `out_valid` stay fixed until `out_ready` takes the cell. Back-pressure on the output never blocks the input, because output cells stay in the shared pool.

Top module: `vcm_merge_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the whole pool is free.
- R2: A cell is looked up by (port, header VCI) among the enabled table entries. A cell that matches no enabled entry is accepted and discarded, and nothing of it appears at the output.
- R3: No cell of a packet appears at the output before the cell ending that packet has been accepted (no cut-through).
- R4: The cells of a packet leave back to back, in arrival order. Packets leave in the order in which they completed.
- R5: An output header equals the input header with the VCI field (bits 27:12) replaced by the context's outgoing VCI. All other header bits and the payload are unchanged. The end-of-packet flag is header bit 9.
- R6: Contexts that share an outgoing VCI produce packets under that one VCI, never interleaved with each other.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_hdr` and `out_payload` hold their values.
- R8: `in_ready` is 0 only when `in_valid` is 1 and the matched context holds a completed packet not yet moved. The move happens on the next clock edge.
- R9: With the output queue empty, `out_valid` rises one clock edge after the edge that accepts an end-of-packet cell.
- R10: When no pool slot is free, the arriving cell is dropped. Its context then drops all cells through the next end-of-packet cell, and the cells it held return to the pool. None of that packet is output.
- R11: Free slots plus cells held in all reassembly queues and the output queue always equal `POOL_CELLS`. A context can fill the whole pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one context table entry |
| cfg_idx | input | $clog2(NUM_VC) | Entry index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_port | input | PORT_W | Source port the entry matches |
| cfg_vci | input | 16 | Incoming VCI the entry matches |
| cfg_out_vci | input | 16 | Outgoing VCI written into the entry's cells |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Input cell taken this cycle |
| in_port | input | PORT_W | Source port of the input cell |
| in_hdr | input | 40 | Cell header (VCI in 27:12, end-of-packet in bit 9) |
| in_payload | input | PAYLOAD_W | Cell payload |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Consumer takes the output cell |
| out_hdr | output | 40 | Translated cell header |
| out_payload | output | PAYLOAD_W | Cell payload |

## Verification
A table of cells from four contexts is tried first. Two of the contexts share one outgoing VCI, their packets are started in an interleaved pattern, and cells from an unknown circuit and from a disabled entry are mixed in. This pattern separates atomic packet release from cell-order forwarding, and shows label merging and lookup filtering. The table is drained under stalling and free-flowing output to separate hold behaviour from transfer order. A single-cell packet followed at once by another cell on the same context measures the release latency and the input stall. Finally, one context fills the whole pool. A second context then overflows, and its packet is ended while in discard mode. This shows the exact pool capacity, the discard window through end-of-packet, the return of held cells and clean recovery afterwards.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // Cell header layout; the VCI field and end-of-packet bit are decoded here
  localparam int HDR_W   = 40;
  localparam int VCI_W   = 16;
  localparam int VCI_LSB = 12;
  localparam int EOP_BIT = 9;
endpackage

// File: rtl/vcm_ctx_table.sv
module vcm_ctx_table #(
  parameter int NUM_VC = 16,
  parameter int PORT_W = 4,
  parameter int VCI_W  = 16,
  localparam int VC_IW = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [VC_IW-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [VCI_W-1:0]  cfg_vci,
  input  logic [VCI_W-1:0]  cfg_out_vci,
  input  logic [PORT_W-1:0] lk_port,
  input  logic [VCI_W-1:0]  lk_vci,
  output logic              lk_hit,
  output logic [VC_IW-1:0]  lk_idx,
  output logic [VCI_W-1:0]  lk_out_vci
);
  logic [NUM_VC-1:0]             ent_en;
  logic [NUM_VC-1:0][PORT_W-1:0] ent_port;
  logic [NUM_VC-1:0][VCI_W-1:0]  ent_vci;
  logic [NUM_VC-1:0][VCI_W-1:0]  ent_out;
  logic [NUM_VC-1:0]             match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_en   <= '0;
      ent_port <= '0;
      ent_vci  <= '0;
      ent_out  <= '0;
    end else if (cfg_we) begin
      ent_en[cfg_idx]   <= cfg_en;
      ent_port[cfg_idx] <= cfg_port;
      ent_vci[cfg_idx]  <= cfg_vci;
      ent_out[cfg_idx]  <= cfg_out_vci;
    end
  end

  for (genvar e = 0; e < NUM_VC; e++) begin : g_cmp
    assign match[e] = ent_en[e] && (ent_port[e] == lk_port) && (ent_vci[e] == lk_vci);
  end

  // lowest matching index wins if the table holds duplicates
  always_comb begin
    lk_hit     = 1'b0;
    lk_idx     = '0;
    lk_out_vci = '0;
    for (int e = NUM_VC - 1; e >= 0; e--) begin
      if (match[e]) begin
        lk_hit     = 1'b1;
        lk_idx     = VC_IW'(e);
        lk_out_vci = ent_out[e];
      end
    end
  end
endmodule

// File: rtl/vcm_rr_arb.sv
module vcm_rr_arb #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int off = 0; off < N; off++) begin
      int k;
      k = int'(ptr) + off;
      if (k >= N) k = k - N;
      if (!gnt_any && req[k]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(k);
        gnt[k]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (gnt_any) begin
      ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
    end
  end
endmodule

// File: rtl/vcm_cell_store.sv
module vcm_cell_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 424,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vcm_merge_unit.sv
module vcm_merge_unit
  import vcm_pkg::*;
#(
  parameter int NUM_VC     = 16,
  parameter int POOL_CELLS = 256,
  parameter int PORT_W     = 4,
  parameter int PAYLOAD_W  = 384
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_VC)-1:0] cfg_idx,
  input  logic                      cfg_en,
  input  logic [PORT_W-1:0]         cfg_port,
  input  logic [15:0]               cfg_vci,
  input  logic [15:0]               cfg_out_vci,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [PORT_W-1:0]         in_port,
  input  logic [39:0]               in_hdr,
  input  logic [PAYLOAD_W-1:0]      in_payload,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [39:0]               out_hdr,
  output logic [PAYLOAD_W-1:0]      out_payload
);
  localparam int VC_IW  = $clog2(NUM_VC);
  localparam int PTR_W  = $clog2(POOL_CELLS);
  localparam int CNT_W  = $clog2(POOL_CELLS + 1);
  localparam int CELL_W = HDR_W + PAYLOAD_W;

  // context lookup
  logic             hit;
  logic [VC_IW-1:0] cidx;
  logic [VCI_W-1:0] xvci;

  vcm_ctx_table #(.NUM_VC(NUM_VC), .PORT_W(PORT_W), .VCI_W(VCI_W)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_port(cfg_port),
    .cfg_vci(cfg_vci), .cfg_out_vci(cfg_out_vci),
    .lk_port(in_port), .lk_vci(in_hdr[VCI_LSB +: VCI_W]),
    .lk_hit(hit), .lk_idx(cidx), .lk_out_vci(xvci)
  );

  // pool state
  logic [PTR_W-1:0] link_q [POOL_CELLS];
  logic [PTR_W-1:0] free_head;
  logic [CNT_W-1:0] free_cnt;
  logic [PTR_W-1:0] oq_head, oq_tail;
  logic [CNT_W-1:0] oq_cnt;

  // per-context reassembly state
  logic [NUM_VC-1:0][PTR_W-1:0] vc_head, vc_tail;
  logic [NUM_VC-1:0][CNT_W-1:0] vc_cnt;
  logic [NUM_VC-1:0]            vc_done, vc_purge, vc_discard;

  // transfer slot arbitration
  logic [NUM_VC-1:0] gnt;
  logic [VC_IW-1:0]  g;
  logic              g_any;

  vcm_rr_arb #(.N(NUM_VC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(vc_done),
    .gnt(gnt), .gnt_idx(g), .gnt_any(g_any)
  );

  // input decisions
  logic is_eop, accept, store, drop_ctx, pop, do_move, do_purge;
  logic [HDR_W-1:0] hdr_x;
  logic [CNT_W-1:0] oq_left, purge_amt;
  logic [PTR_W-1:0] h1, h2, h3;

  assign is_eop    = in_hdr[EOP_BIT];
  assign in_ready  = !(in_valid && hit && vc_done[cidx]);
  assign accept    = in_valid && in_ready;
  assign store     = accept && hit && !vc_discard[cidx] && (free_cnt != '0);
  assign drop_ctx  = accept && hit && !store;
  assign out_valid = (oq_cnt != '0);
  assign pop       = out_valid && out_ready;
  assign do_move   = g_any && !vc_purge[g];
  assign do_purge  = g_any && vc_purge[g];
  assign oq_left   = oq_cnt - CNT_W'(pop);
  assign purge_amt = do_purge ? vc_cnt[g] : '0;

  always_comb begin
    hdr_x = in_hdr;
    hdr_x[VCI_LSB +: VCI_W] = xvci;
  end

  // free list head after allocation, then freed output cell, then purged chain
  assign h1 = store ? link_q[free_head] : free_head;
  assign h2 = pop ? oq_head : h1;
  assign h3 = do_purge ? vc_head[g] : h2;

  // cell data storage
  logic [CELL_W-1:0] rd_cell;

  vcm_cell_store #(.DEPTH(POOL_CELLS), .DATA_W(CELL_W)) u_store (
    .clk(clk), .wr_en(store), .wr_addr(free_head),
    .wr_data({hdr_x, in_payload}), .rd_addr(oq_head), .rd_data(rd_cell)
  );

  assign out_hdr     = rd_cell[CELL_W-1 -: HDR_W];
  assign out_payload = rd_cell[PAYLOAD_W-1:0];

  // link array: each write targets a cell owned by a different list
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < POOL_CELLS; i++) link_q[i] <= PTR_W'(i + 1);
    end else begin
      if (store && vc_cnt[cidx] != '0) link_q[vc_tail[cidx]] <= free_head;
      if (do_move && oq_left != '0)    link_q[oq_tail]       <= vc_head[g];
      if (pop)                         link_q[oq_head]       <= h1;
      if (do_purge)                    link_q[vc_tail[g]]    <= h2;
    end
  end

  // pool and output queue pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_head <= '0;
      free_cnt  <= CNT_W'(POOL_CELLS);
      oq_head   <= '0;
      oq_tail   <= '0;
      oq_cnt    <= '0;
    end else begin
      free_head <= h3;
      free_cnt  <= free_cnt - CNT_W'(store) + CNT_W'(pop) + purge_amt;
      if (pop) oq_head <= link_q[oq_head];
      if (do_move) begin
        if (oq_left == '0) oq_head <= vc_head[g];
        oq_tail <= vc_tail[g];
        oq_cnt  <= oq_left + vc_cnt[g];
      end else begin
        oq_cnt <= oq_left;
      end
    end
  end

  // context state; the stalled context is never the granted one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vc_head    <= '0;
      vc_tail    <= '0;
      vc_cnt     <= '0;
      vc_done    <= '0;
      vc_purge   <= '0;
      vc_discard <= '0;
    end else begin
      if (g_any) begin
        vc_cnt[g]   <= '0;
        vc_done[g]  <= 1'b0;
        vc_purge[g] <= 1'b0;
      end
      if (store) begin
        if (vc_cnt[cidx] == '0) vc_head[cidx] <= free_head;
        vc_tail[cidx] <= free_head;
        vc_cnt[cidx]  <= vc_cnt[cidx] + CNT_W'(1);
        if (is_eop) vc_done[cidx] <= 1'b1;
      end
      if (drop_ctx) begin
        if (is_eop) begin
          vc_discard[cidx] <= 1'b0;
          if (vc_cnt[cidx] != '0) begin
            vc_done[cidx]  <= 1'b1;
            vc_purge[cidx] <= 1'b1;
          end
        end else begin
          vc_discard[cidx] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vcm_merge_unit_chk.sv
module vcm_merge_unit_chk #(
  parameter int NUM_VC     = 16,
  parameter int POOL_CELLS = 256,
  parameter int PAYLOAD_W  = 384,
  localparam int CNT_W = $clog2(POOL_CELLS + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [39:0]                   out_hdr,
  input logic [PAYLOAD_W-1:0]          out_payload,
  input logic [CNT_W-1:0]              free_cnt,
  input logic [CNT_W-1:0]              oq_cnt,
  input logic [NUM_VC-1:0][CNT_W-1:0]  vc_cnt,
  input logic [NUM_VC-1:0]             vc_done,
  input logic [NUM_VC-1:0]             gnt
);
  logic [CNT_W+8:0] held_sum;
  always_comb begin
    held_sum = (CNT_W+9)'(free_cnt) + (CNT_W+9)'(oq_cnt);
    for (int v = 0; v < NUM_VC; v++) held_sum = held_sum + (CNT_W+9)'(vc_cnt[v]);
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) && $stable(out_payload)));

  // R8
  in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> in_valid);

  // R3
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_cnt > $past(oq_cnt)) |-> $past(|vc_done));

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R11
  pool_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_sum == (CNT_W+9)'(POOL_CELLS));
endmodule

bind vcm_merge_unit vcm_merge_unit_chk #(
  .NUM_VC(NUM_VC), .POOL_CELLS(POOL_CELLS), .PAYLOAD_W(PAYLOAD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
  .out_payload(out_payload), .free_cnt(free_cnt), .oq_cnt(oq_cnt),
  .vc_cnt(vc_cnt), .vc_done(vc_done), .gnt(gnt)
);

// File: tb/vcm_merge_unit_bench.sv
module vcm_merge_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VC = 16;
  localparam int POOL   = 256;
  localparam int PW     = 4;
  localparam int PLW    = 384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [PW-1:0] cfg_port = '0;
  logic [15:0] cfg_vci = '0, cfg_out_vci = '0;
  logic in_valid = 1'b0, in_ready;
  logic [PW-1:0] in_port = '0;
  logic [39:0] in_hdr = '0;
  logic [PLW-1:0] in_payload = '0;
  logic out_valid, out_ready = 1'b0;
  logic [39:0] out_hdr;
  logic [PLW-1:0] out_payload;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcm_merge_unit u_vcm_merge_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_port(cfg_port), .cfg_vci(cfg_vci), .cfg_out_vci(cfg_out_vci),
    .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port), .in_hdr(in_hdr),
    .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_payload(out_payload)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 1'b0;

  // stimulus: {port, vci, eop, tag}
  localparam logic [28:0] STIM [9] = '{
    {4'd1, 16'd100, 1'b0, 8'h01},
    {4'd2, 16'd100, 1'b0, 8'h02},
    {4'd1, 16'd100, 1'b1, 8'h03},
    {4'd1, 16'd200, 1'b1, 8'h04},
    {4'd2, 16'd100, 1'b0, 8'h05},
    {4'd2, 16'd100, 1'b1, 8'h06},
    {4'd5, 16'd100, 1'b1, 8'h07},
    {4'd3, 16'd7,   1'b1, 8'h08},
    {4'd6, 16'd9,   1'b1, 8'h09}
  };
  // expected output: {vci, eop, tag}
  localparam logic [24:0] EXPV [7] = '{
    {16'd500, 1'b0, 8'h01}, {16'd500, 1'b1, 8'h03}, {16'd600, 1'b1, 8'h04},
    {16'd500, 1'b0, 8'h02}, {16'd500, 1'b0, 8'h05}, {16'd500, 1'b1, 8'h06},
    {16'd700, 1'b1, 8'h08}
  };

  function automatic logic [39:0] mk_hdr(input logic [15:0] v, input logic e);
    return {4'h3, 8'h12, v, 2'b00, e, 1'b0, 8'h5A};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(input int idx, input logic en, input logic [3:0] p,
                     input logic [15:0] v, input logic [15:0] ov);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_port = p;
    cfg_vci = v; cfg_out_vci = ov;
    @(posedge clk); #1; cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] p, input logic [15:0] v, input logic e,
                       input logic [7:0] tag);
    in_valid = 1'b1; in_port = p; in_hdr = mk_hdr(v, e); in_payload = {48{tag}};
  endtask

  // entered and left at a negative edge
  task automatic send(input logic [3:0] p, input logic [15:0] v, input logic e,
                      input logic [7:0] tag);
    int w;
    drive(p, v, e, tag);
    #1;
    w = 0;
    while (!in_ready && w < 50) begin @(negedge clk); w++; end
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_cell(input string req, input logic [15:0] v, input logic e,
                             input logic [7:0] tag);
    int w;
    out_ready = 1'b1;
    w = 0;
    while (!out_valid && w < 40) begin @(negedge clk); w++; end
    check(req, 64'(out_valid), 64'(1));
    check(req, 64'(out_hdr), 64'(mk_hdr(v, e)));
    n_chk++;
    if (out_payload !== {48{tag}}) begin
      n_bad++;
      $display("FAIL %s: payload actual %0h expected tag %0h", req, out_payload[7:0], tag);
    end
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 64'(out_valid), 64'(0));
    check("R1 in_ready", 64'(in_ready), 64'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", 64'(out_valid), 64'(0));

    cfg(0, 1'b1, 4'd1, 16'd100, 16'd500);
    cfg(1, 1'b1, 4'd2, 16'd100, 16'd500);
    cfg(2, 1'b1, 4'd1, 16'd200, 16'd600);
    cfg(3, 1'b1, 4'd3, 16'd7,   16'd700);
    cfg(4, 1'b0, 4'd6, 16'd9,   16'd900);

    // table-driven main flow, output stalled
    for (int i = 0; i < 9; i++) begin
      send(STIM[i][28:25], STIM[i][24:9], STIM[i][8], STIM[i][7:0]);
      if (i == 1) check("R3 no cut-through", 64'(out_valid), 64'(0));
    end
    repeat (2) @(negedge clk);
    check("R7 valid under stall", 64'(out_valid), 64'(1));
    held = out_hdr;
    @(negedge clk);
    check("R7 header held", 64'(out_hdr), 64'(held));

    for (int k = 0; k < 7; k++) begin
      if (k % 2 == 1) begin
        out_ready = 1'b0;
        held = out_hdr;
        @(negedge clk);
        check("R7 hold on stall", 64'(out_hdr), 64'(held));
      end
      expect_cell("R4 R5 R6 order/label", EXPV[k][24:9], EXPV[k][8], EXPV[k][7:0]);
    end
    check("R2 R4 no extra cells", 64'(out_valid), 64'(0));
    out_ready = 1'b0;

    // latency and same-context stall
    drive(4'd3, 16'd7, 1'b1, 8'h61);
    @(posedge clk); #1;
    drive(4'd3, 16'd7, 1'b1, 8'h62);
    @(negedge clk);
    check("R8 stall while packet waits", 64'(in_ready), 64'(0));
    check("R9 not yet valid", 64'(out_valid), 64'(0));
    @(negedge clk);
    check("R8 stall released", 64'(in_ready), 64'(1));
    check("R9 valid one edge later", 64'(out_valid), 64'(1));
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    expect_cell("R9 latency cell", 16'd700, 1'b1, 8'h61);
    expect_cell("R8 queued cell", 16'd700, 1'b1, 8'h62);
    out_ready = 1'b0;

    // pool exhaustion and discard through end of packet
    for (int n = 0; n < POOL - 1; n++) send(4'd1, 16'd100, 1'b0, 8'hA0);
    check("R3 R11 full context held", 64'(out_valid), 64'(0));
    send(4'd1, 16'd200, 1'b0, 8'h40);
    send(4'd1, 16'd200, 1'b0, 8'h41);
    send(4'd1, 16'd100, 1'b1, 8'hA1);
    send(4'd1, 16'd200, 1'b0, 8'h42);
    send(4'd1, 16'd200, 1'b1, 8'h43);
    repeat (2) @(negedge clk);
    check("R10 nothing of dropped packets", 64'(out_valid), 64'(0));
    send(4'd1, 16'd200, 1'b0, 8'h51);
    send(4'd1, 16'd200, 1'b1, 8'h52);
    expect_cell("R10 R11 recovery first", 16'd600, 1'b0, 8'h51);
    expect_cell("R10 R11 recovery second", 16'd600, 1'b1, 8'h52);
    repeat (3) @(negedge clk);
    check("R10 no purged cells", 64'(out_valid), 64'(0));

    finish_run();
  end
endmodule